// File: doc/BRIEF.md
# Store gathering write buffer

This block sits on the store path of a data cache. Each store arrives with a 16-byte line index, a per-byte lane mask, the data lanes, the page attributes (write-through, caching-inhibited, no-allocate) and the cache hit status. The block routes the store. The store may be written into the cache, may request a line fill, and may be sent towards memory. The stores bound for memory are combined into one gathering entry. That entry leaves as a single memory write of up to 16 bytes in one aligned region.

A store is bound for memory when its page is caching-inhibited or write-through, or when it misses on a no-allocate page. A miss on an allocate page asks the fill engine for the line and writes the store into the cache. The entry is written out in three cases: a store arrives that cannot be merged into it, it has stayed idle for a set number of cycles, or a drain is requested.

The store input and the memory output are valid/ready streams. A store is taken on a cycle with `st_valid` and `st_ready` both high. `st_ready` is low while a memory write waits for `mem_ready` and while `drain_req` is high. A memory write is taken on a cycle with `mem_valid` and `mem_ready` both high. Until then its address, mask and data stay unchanged.

Top module: `store_gather_buf`

## Requirements
- R1: After reset `mem_valid`, `fill_req` and `cache_wr` are 0 and `st_ready` is 1.
- R2: A store is gathered for memory only if `st_ci`=1, or `st_wt`=1, or (`st_hit`=0 and `st_noalloc`=1). A copy-back store that hits, or that misses on an allocate page, never produces a memory write, even after a drain.
- R3: A store taken with `st_ci`=0, `st_hit`=0 and `st_noalloc`=0 raises `fill_req` in its accept cycle, with `fill_addr` = `st_line`×16. A no-allocate miss raises neither `fill_req` nor `cache_wr`.
- R4: `cache_wr` is high in the accept cycle of every store with `st_ci`=0 that either hits or misses on an allocate page. It is never high for a caching-inhibited store.
- R5: A gathered store merges into the open entry when three conditions hold: the line index matches, the caching-inhibited attribute matches, and the union of the lane masks has no gap. Bit i of a mask is byte i of the region. The merged write carries the OR of the masks. On overlapping lanes the newer store's bytes win. Lanes that no store enabled read as zero.
- R6: A gathered store that cannot merge pushes the open entry out as its own memory write, and then opens a new entry. Memory writes leave in the order in which their entries were opened.
- R7: An entry that receives no store is written out at the TIMEOUT-th clock edge after the edge that last opened or merged it.
- R8: A store that merges in the cycle the idle limit is reached cancels that expiry and restarts the idle count.
- R9: While `drain_req` is high `st_ready` is 0. The open entry is written out as soon as no memory write is pending.
- R10: While `mem_valid` is high and `mem_ready` is low, `mem_valid` stays high and `mem_addr`, `mem_be` and `mem_data` keep their values. `st_ready` is 0 while `mem_valid` is high.
- R11: Every memory write has `mem_addr` aligned to 16 bytes (low four bits zero) and a nonzero `mem_be`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store present |
| st_ready | output | 1 | Store can be taken |
| st_line | input | ADDR_W-4 | 16-byte region index of the store |
| st_be | input | 16 | Byte lane mask of the store |
| st_data | input | 128 | Store data, byte i in bits 8i+7:8i |
| st_wt | input | 1 | Page is write-through |
| st_ci | input | 1 | Page is caching-inhibited |
| st_noalloc | input | 1 | Page does not allocate on store miss |
| st_hit | input | 1 | Store hits in the cache |
| drain_req | input | 1 | Write out the open entry |
| mem_valid | output | 1 | Memory write present |
| mem_ready | input | 1 | Memory takes the write |
| mem_addr | output | ADDR_W | Aligned byte address of the write |
| mem_be | output | 16 | Byte lane mask of the write |
| mem_data | output | 128 | Write data |
| fill_req | output | 1 | Line fill request, one per allocate miss |
| fill_addr | output | ADDR_W | Aligned address of the line to fill |
| cache_wr | output | 1 | Store is written into the cache |

## Verification
Two events can fall in the same cycle: the idle count reaches its limit, and a mergeable store is taken. The bench opens an entry and waits TIMEOUT-1 edges. It then sends a second store to the same region so that it is taken on exactly the edge that would have expired the entry. The bench judges the outcome by timing. `mem_valid` must stay low across that edge and for a further TIMEOUT-1 edges. It must then rise with the merged lane mask, which shows that the merge won and restarted the idle count.

// File: rtl/sgwb_pkg.sv
package sgwb_pkg;

  // Where an accepted store goes
  typedef struct packed {
    logic gather;    // towards memory through the gathering entry
    logic to_cache;  // written into the data array
    logic fill;      // line fill must be requested
  } st_route_t;

  function automatic st_route_t route_store(input logic ci, input logic wt,
                                            input logic noalloc, input logic hit);
    st_route_t r;
    r.gather   = ci | wt | (~hit & noalloc);
    r.to_cache = ~ci & (hit | ~noalloc);
    r.fill     = ~ci & ~hit & ~noalloc;
    return r;
  endfunction

endpackage

// File: rtl/sgwb_router.sv
module sgwb_router
  import sgwb_pkg::*;
(
  input  logic      ci,
  input  logic      wt,
  input  logic      noalloc,
  input  logic      hit,
  output st_route_t route
);
  always_comb route = route_store(ci, wt, noalloc, hit);
endmodule

// File: rtl/sgwb_mergeable.sv
module sgwb_mergeable #(
  parameter int LANES = 16,
  parameter int TAG_W = 28
) (
  input  logic             ent_valid,
  input  logic [TAG_W-1:0] ent_tag,
  input  logic [LANES-1:0] ent_be,
  input  logic             ent_ci,
  input  logic [TAG_W-1:0] st_tag,
  input  logic [LANES-1:0] st_be,
  input  logic             st_ci,
  output logic             can_merge
);
  logic [LANES-1:0] lane_union;
  logic [LANES-1:0] run_start;

  always_comb begin
    lane_union = ent_be | st_be;
    // a set bit whose lower neighbour is clear starts a run of lanes
    run_start  = lane_union & ~(lane_union << 1);
    can_merge  = ent_valid && (ent_tag == st_tag) && (ent_ci == st_ci) &&
                 ($countones(run_start) <= 1);
  end
endmodule

// File: rtl/sgwb_entry.sv
module sgwb_entry #(
  parameter int LANES   = 16,
  parameter int TAG_W   = 28,
  parameter int TIMEOUT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               merge,
  input  logic               flush,
  input  logic [TAG_W-1:0]   in_tag,
  input  logic [LANES-1:0]   in_be,
  input  logic [LANES*8-1:0] in_data,
  input  logic               in_ci,
  output logic               ent_valid,
  output logic [TAG_W-1:0]   ent_tag,
  output logic [LANES-1:0]   ent_be,
  output logic [LANES*8-1:0] ent_data,
  output logic               ent_ci,
  output logic               expired
);
  localparam int CNT_W = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT - 1);

  logic [CNT_W-1:0] idle_q;
  logic [7:0]       lane_q [LANES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_valid <= 1'b0;
      ent_tag   <= '0;
      ent_be    <= '0;
      ent_ci    <= 1'b0;
      idle_q    <= '0;
    end else if (load) begin
      ent_valid <= 1'b1;
      ent_tag   <= in_tag;
      ent_be    <= in_be;
      ent_ci    <= in_ci;
      idle_q    <= '0;
    end else if (merge) begin
      ent_be    <= ent_be | in_be;
      idle_q    <= '0;
    end else if (flush) begin
      ent_valid <= 1'b0;
      idle_q    <= '0;
    end else if (ent_valid && idle_q != LIMIT) begin
      idle_q    <= idle_q + CNT_W'(1);
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (load)
        lane_q[g] <= in_be[g] ? in_data[g*8 +: 8] : 8'h00;
      else if (merge && in_be[g])
        lane_q[g] <= in_data[g*8 +: 8];
    end
    assign ent_data[g*8 +: 8] = lane_q[g];
  end

  assign expired = ent_valid && (idle_q == LIMIT);
endmodule

// File: rtl/sgwb_outreg.sv
module sgwb_outreg #(
  parameter int LANES  = 16,
  parameter int ADDR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture,
  input  logic [ADDR_W-1:0]  in_addr,
  input  logic [LANES-1:0]   in_be,
  input  logic [LANES*8-1:0] in_data,
  output logic               mem_valid,
  input  logic               mem_ready,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [LANES-1:0]   mem_be,
  output logic [LANES*8-1:0] mem_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_data  <= '0;
    end else if (capture) begin
      mem_valid <= 1'b1;
      mem_addr  <= in_addr;
      mem_be    <= in_be;
      mem_data  <= in_data;
    end else if (mem_ready) begin
      mem_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/store_gather_buf.sv
module store_gather_buf
  import sgwb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LANES   = 16,
  parameter int TIMEOUT = 8,
  localparam int OFF_W  = $clog2(LANES),
  localparam int TAG_W  = ADDR_W - OFF_W,
  localparam int DATA_W = LANES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [TAG_W-1:0]  st_line,
  input  logic [LANES-1:0]  st_be,
  input  logic [DATA_W-1:0] st_data,
  input  logic              st_wt,
  input  logic              st_ci,
  input  logic              st_noalloc,
  input  logic              st_hit,
  input  logic              drain_req,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_be,
  output logic [DATA_W-1:0] mem_data,
  output logic              fill_req,
  output logic [ADDR_W-1:0] fill_addr,
  output logic              cache_wr
);
  st_route_t         route;
  logic              st_fire, g_fire, can_merge, do_merge, do_load, do_flush;
  logic              ent_valid, ent_ci, expired;
  logic [TAG_W-1:0]  ent_tag;
  logic [LANES-1:0]  ent_be;
  logic [DATA_W-1:0] ent_data;

  sgwb_router u_router (
    .ci(st_ci), .wt(st_wt), .noalloc(st_noalloc), .hit(st_hit), .route(route)
  );

  sgwb_mergeable #(.LANES(LANES), .TAG_W(TAG_W)) u_mergeable (
    .ent_valid(ent_valid), .ent_tag(ent_tag), .ent_be(ent_be), .ent_ci(ent_ci),
    .st_tag(st_line), .st_be(st_be), .st_ci(st_ci), .can_merge(can_merge)
  );

  // Stores stall while a write waits on memory and while a drain is asked for
  assign st_ready = !mem_valid && !drain_req;
  assign st_fire  = st_valid && st_ready;
  assign g_fire   = st_fire && route.gather;
  assign do_merge = g_fire && can_merge;
  assign do_load  = g_fire && !can_merge;

  // Output stage is free whenever a flush is chosen; a merge outranks expiry
  assign do_flush = ent_valid && !mem_valid &&
                    (do_load || (expired && !do_merge) || drain_req);

  sgwb_entry #(.LANES(LANES), .TAG_W(TAG_W), .TIMEOUT(TIMEOUT)) u_entry (
    .clk(clk), .rst_n(rst_n), .load(do_load), .merge(do_merge), .flush(do_flush),
    .in_tag(st_line), .in_be(st_be), .in_data(st_data), .in_ci(st_ci),
    .ent_valid(ent_valid), .ent_tag(ent_tag), .ent_be(ent_be),
    .ent_data(ent_data), .ent_ci(ent_ci), .expired(expired)
  );

  sgwb_outreg #(.LANES(LANES), .ADDR_W(ADDR_W)) u_outreg (
    .clk(clk), .rst_n(rst_n), .capture(do_flush),
    .in_addr({ent_tag, {OFF_W{1'b0}}}), .in_be(ent_be), .in_data(ent_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_data(mem_data)
  );

  assign fill_req  = st_fire && route.fill;
  assign fill_addr = {st_line, {OFF_W{1'b0}}};
  assign cache_wr  = st_fire && route.to_cache;
endmodule

// File: rtl/store_gather_buf_chk.sv
module store_gather_buf_chk #(
  parameter int ADDR_W = 32,
  parameter int LANES  = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 st_valid,
  input logic                 st_ready,
  input logic                 st_ci,
  input logic                 st_hit,
  input logic                 drain_req,
  input logic                 mem_valid,
  input logic                 mem_ready,
  input logic [ADDR_W-1:0]    mem_addr,
  input logic [LANES-1:0]     mem_be,
  input logic [LANES*8-1:0]   mem_data,
  input logic                 fill_req,
  input logic                 cache_wr
);
  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid); // R10
  AST_HOLD_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> $stable(mem_addr) && $stable(mem_be) && $stable(mem_data)); // R10
  AST_STALL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !st_ready); // R10
  AST_DRAIN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    drain_req |-> !st_ready); // R9
  AST_WRITE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_be != '0) && (mem_addr[$clog2(LANES)-1:0] == '0)); // R11
  AST_CI_NO_CACHE: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && st_ready && st_ci |-> !cache_wr && !fill_req); // R4
  AST_FILL_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> !st_hit && cache_wr); // R3
endmodule

bind store_gather_buf store_gather_buf_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
  .st_ci(st_ci), .st_hit(st_hit), .drain_req(drain_req),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
  .mem_be(mem_be), .mem_data(mem_data), .fill_req(fill_req), .cache_wr(cache_wr)
);

// File: tb/test_store_gather_buf.sv
`timescale 1ns/1ps
module test_store_gather_buf;
  localparam int TO = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         st_valid, st_ready;
  logic [27:0]  st_line;
  logic [15:0]  st_be;
  logic [127:0] st_data;
  logic         st_wt, st_ci, st_noalloc, st_hit, drain_req;
  logic         mem_valid, mem_ready;
  logic [31:0]  mem_addr;
  logic [15:0]  mem_be;
  logic [127:0] mem_data;
  logic         fill_req, cache_wr;
  logic [31:0]  fill_addr;

  int checks = 0;
  int errors = 0;
  logic         fill_q, cw_q;
  logic [31:0]  fa_q;

  always #2 clk = ~clk;

  store_gather_buf #(.ADDR_W(32), .LANES(16), .TIMEOUT(TO)) i_store_gather_buf (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_line(st_line), .st_be(st_be), .st_data(st_data), .st_wt(st_wt),
    .st_ci(st_ci), .st_noalloc(st_noalloc), .st_hit(st_hit),
    .drain_req(drain_req), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_data(mem_data),
    .fill_req(fill_req), .fill_addr(fill_addr), .cache_wr(cache_wr)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // lanes of d selected by be replace the same lanes of old
  function automatic logic [127:0] lanes(input logic [127:0] old,
                                         input logic [15:0] be, input logic [127:0] d);
    logic [127:0] r = old;
    for (int i = 0; i < 16; i++) if (be[i]) r[i*8 +: 8] = d[i*8 +: 8];
    return r;
  endfunction

  task automatic put(input logic [27:0] line, input logic [15:0] be,
                     input logic [127:0] d, input logic wt, input logic ci,
                     input logic na, input logic hit);
    @(negedge clk);
    st_line = line; st_be = be; st_data = d;
    st_wt = wt; st_ci = ci; st_noalloc = na; st_hit = hit; st_valid = 1'b1;
    #1;
    for (int n = 0; n < 1000 && !st_ready; n++) begin @(negedge clk); #1; end
    fill_q = fill_req; cw_q = cache_wr; fa_q = fill_addr;
    @(posedge clk); #1;
    st_valid = 1'b0;
  endtask

  task automatic take(input logic [31:0] a, input logic [15:0] be,
                      input logic [127:0] d, input string req);
    mem_ready = 1'b1;
    @(negedge clk);
    for (int n = 0; n < 100 && !mem_valid; n++) @(negedge clk);
    chk(mem_valid == 1'b1, {req, " write present"}, 128'(mem_valid), 128'd1);
    chk(mem_addr == a, {req, " address"}, 128'(mem_addr), 128'(a));
    chk(mem_be == be, {req, " lane mask"}, 128'(mem_be), 128'(be));
    chk(mem_data == d, {req, " data"}, mem_data, d);
    @(posedge clk); #1;
    mem_ready = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    drain_req = 1'b1;
    #1;
    chk(st_ready == 1'b0, "R9 stall during drain", 128'(st_ready), 128'd0);
    @(posedge clk); #1;
    drain_req = 1'b0;
  endtask

  task automatic quiet(input int cycles, input string req);
    logic seen = 1'b0;
    repeat (cycles) begin @(negedge clk); seen |= mem_valid; end
    chk(seen == 1'b0, req, 128'(seen), 128'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(mem_valid == 1'b0, "R1 mem_valid", 128'(mem_valid), 128'd0);
    chk(st_ready == 1'b1, "R1 st_ready", 128'(st_ready), 128'd1);
    chk(fill_req == 1'b0 && cache_wr == 1'b0, "R1 fill/cache",
        128'({fill_req, cache_wr}), 128'd0);
  endtask

  task automatic t_copyback();
    put(28'h10, 16'hFFFF, {4{32'hA5A5_0001}}, 1'b0, 1'b0, 1'b0, 1'b1);
    chk(cw_q == 1'b1 && fill_q == 1'b0, "R4 copy-back hit to cache",
        128'({cw_q, fill_q}), 128'b10);
    drain();
    quiet(6, "R2 copy-back hit not gathered");
  endtask

  task automatic t_alloc_miss();
    put(28'h20, 16'h00F0, {4{32'h0BAD_CAFE}}, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(fill_q == 1'b1, "R3 allocate miss fills", 128'(fill_q), 128'd1);
    chk(fa_q == 32'h200, "R3 fill address", 128'(fa_q), 128'h200);
    chk(cw_q == 1'b1, "R4 allocate miss to cache", 128'(cw_q), 128'd1);
    drain();
    quiet(6, "R2 allocate miss not gathered");
  endtask

  task automatic t_noalloc_miss();
    logic [127:0] d = {4{32'h1234_5678}};
    put(28'h30, 16'h000F, d, 1'b0, 1'b0, 1'b1, 1'b0);
    chk(fill_q == 1'b0 && cw_q == 1'b0, "R3 no-allocate miss bypasses",
        128'({fill_q, cw_q}), 128'd0);
    drain();
    take(32'h300, 16'h000F, lanes('0, 16'h000F, d), "R2 no-allocate miss gathered");
  endtask

  task automatic t_merge();
    logic [127:0] a = {4{32'h1111_2222}};
    logic [127:0] b = {4{32'h3333_4444}};
    logic [127:0] c = {4{32'h5555_6666}};
    logic [127:0] e;
    put(28'h40, 16'h000F, a, 1'b1, 1'b0, 1'b0, 1'b1);
    chk(cw_q == 1'b1, "R4 write-through hit to cache", 128'(cw_q), 128'd1);
    put(28'h40, 16'h00F0, b, 1'b1, 1'b0, 1'b0, 1'b1);
    put(28'h40, 16'h0018, c, 1'b1, 1'b0, 1'b0, 1'b1);
    e = lanes(lanes(lanes('0, 16'h000F, a), 16'h00F0, b), 16'h0018, c);
    drain();
    take(32'h400, 16'h00FF, e, "R5 merged write");
    quiet(4, "R5 single write for merged stores");
  endtask

  task automatic t_split();
    logic [127:0] a = {4{32'hAAAA_0001}};
    logic [127:0] b = {4{32'hBBBB_0002}};
    logic [127:0] c = {4{32'hCCCC_0003}};
    put(28'h50, 16'h000F, a, 1'b0, 1'b1, 1'b0, 1'b0);
    put(28'h50, 16'h0F00, b, 1'b0, 1'b1, 1'b0, 1'b0);
    take(32'h500, 16'h000F, lanes('0, 16'h000F, a), "R6 gap pushes first entry");
    put(28'h60, 16'hF000, c, 1'b0, 1'b1, 1'b0, 1'b0);
    take(32'h500, 16'h0F00, lanes('0, 16'h0F00, b), "R6 second entry in order");
    drain();
    take(32'h600, 16'hF000, lanes('0, 16'hF000, c), "R11 third entry aligned");
  endtask

  task automatic t_timeout();
    logic [127:0] d = {4{32'h7777_8888}};
    put(28'h70, 16'h0003, d, 1'b1, 1'b0, 1'b0, 1'b1);
    repeat (TO - 1) @(posedge clk);
    #1;
    chk(mem_valid == 1'b0, "R7 no write before limit", 128'(mem_valid), 128'd0);
    @(posedge clk); #1;
    chk(mem_valid == 1'b1, "R7 write at limit", 128'(mem_valid), 128'd1);
    repeat (3) @(posedge clk);
    #1;
    chk(mem_valid == 1'b1 && mem_be == 16'h0003, "R10 write held",
        128'({mem_valid, mem_be}), 128'h1_0003);
    chk(st_ready == 1'b0, "R10 stall while write held", 128'(st_ready), 128'd0);
    take(32'h700, 16'h0003, lanes('0, 16'h0003, d), "R10 held write");
  endtask

  task automatic t_restart();
    logic [127:0] a = {4{32'h0102_0304}};
    logic [127:0] b = {4{32'h0506_0708}};
    put(28'h80, 16'h0001, a, 1'b1, 1'b0, 1'b0, 1'b1);
    repeat (TO - 1) @(posedge clk);
    put(28'h80, 16'h0002, b, 1'b1, 1'b0, 1'b0, 1'b1);
    chk(mem_valid == 1'b0, "R8 merge cancels expiry", 128'(mem_valid), 128'd0);
    repeat (TO - 1) @(posedge clk);
    #1;
    chk(mem_valid == 1'b0, "R8 count restarted", 128'(mem_valid), 128'd0);
    @(posedge clk); #1;
    chk(mem_valid == 1'b1, "R8 write after restarted limit", 128'(mem_valid), 128'd1);
    take(32'h800, 16'h0003, lanes(lanes('0, 16'h0001, a), 16'h0002, b), "R8 merged");
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; st_valid = 1'b0; st_line = '0; st_be = '0; st_data = '0;
    st_wt = 1'b0; st_ci = 1'b0; st_noalloc = 1'b0; st_hit = 1'b0;
    drain_req = 1'b0; mem_ready = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_copyback();
    t_alloc_miss();
    t_noalloc_miss();
    t_merge();
    t_split();
    t_timeout();
    t_restart();
    finish_run();
  end
endmodule